// File: doc/BRIEF.md
# Synthesizer Control Serial Slave

This block is the two-wire serial slave that sits in front of a frequency synthesizer's control registers. It watches an oversampled clock line and data line, recognises START and STOP conditions, and answers only the device address whose two low address bits are set by a strap input. When the bus master writes, the block sorts each data byte by its leading bit. A byte that begins with 0 opens a two-byte divide ratio. A byte that begins with 1 carries the charge-pump and mode controls, and the byte after it sets the output-port latches.

When the master reads, the block returns one status byte for each acknowledged byte. The status byte joins a sticky power-on flag with live inputs: the lock flag, three digital port levels and a 3-bit band code. The synthesizer sees only registered outputs. The 15-bit ratio changes in a single step, so a half-written ratio never reaches the divider.

Top module: `synth_ctl_slave`

## Requirements
- R1: The address byte is 1,1,0,0,0, then strap_i[1], strap_i[0], then a direction bit (0 = write, 1 = read), sent MSB first. The slave pulls SDA low in the ninth clock only when all seven address bits match. On a mismatch it stays silent and ignores the bus until the next START.
- R2: Data bytes are shifted in MSB first. The slave pulls SDA low during the ninth clock of every write data byte. sda_oe only changes while SCL is low.
- R3: When a data byte arrives while no pair or port byte is pending and its bit 7 is 0, it opens a divider pair. The ratio becomes {first[6:0], second[7:0]}, so first[6] has weight 2^14 and second[0] has weight 2^0.
- R4: div_ratio changes only on the system clock that follows the acknowledge of a pair's second byte. Between the two bytes it keeps its old value. A lone first byte that is followed by STOP or START is discarded.
- R5: A data byte whose bit 7 is 1 is a control byte: bit 6 to cp_sel, bit 5 to test_en, bit 4 to pump_off, bits 3:1 to mode_sel[2:0], bit 0 to vdrv_off.
- R6: The byte after a control byte is a port byte, whatever its bit 7. Bits 7:3 go to port_q[4:0], with bit 7 in port_q[4]. Bits 2:0 have no effect.
- R7: A read returns the status byte {por, lock_i, port_in[2:0], lvl_in[2:0]}, MSB first. lvl_in encodes five input bands, 000 (lowest) to 100 (highest).
- R8: The power-on flag is 1 after reset. It reads 0 in every status byte that begins after the first complete status byte.
- R9: In a read, an acknowledge from the master produces another status byte. A not-acknowledge makes the slave release SDA and drive nothing until the next START.
- R10: After reset div_ratio, every control field and port_q are 0, and SDA is released.
- R11: Every START, including a repeated START, clears any pending divider half or port expectation. The first data byte after it is classified afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 2 | Selects the two low address bits |
| lock_i | input | 1 | Live phase-lock flag |
| port_in | input | 3 | Live digital port levels |
| lvl_in | input | 3 | Band code from the level comparators |
| div_ratio | output | 15 | Registered divide ratio |
| cp_sel | output | 1 | Charge-pump current select |
| test_en | output | 1 | Test mode enable |
| pump_off | output | 1 | Charge-pump disable |
| mode_sel | output | 3 | Operation mode field |
| vdrv_off | output | 1 | Varactor drive disable |
| port_q | output | 5 | Output-port latches |

## Verification
Two functions meet on one edge here. A START resets the byte classifier, and at that same point the classifier may be holding half of a divider pair. The bench provokes this by writing a lone leading-0 byte and then issuing a repeated START, with a control byte and a port byte behind it. It judges the result at the ports: the control and port fields must take the new bytes, and div_ratio must keep its old value.

// File: rtl/synth_pkg.sv
// Package: shared types and constants for the synthesizer control slave.
// Assumes one byte-wide serial protocol with a fixed 5-bit address prefix.
package synth_pkg;

    // Fixed upper five bits of the device address.
    localparam logic [4:0] DEV_PREFIX = 5'b11000;

    // Bus-level protocol state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } bus_st_t;

    // What the next written data byte is expected to be.
    typedef enum logic [1:0] {
        EXP_ANY,
        EXP_DIV_LO,
        EXP_PORT
    } expect_t;

    // Control byte fields, in bit order below the leading 1.
    typedef struct packed {
        logic       cp;
        logic       test;
        logic       pump_off;
        logic [2:0] mode;
        logic       vdrv_off;
    } ctrl_t;

endpackage

// File: rtl/synth_line_sync.sv
// Module: synchronises the serial clock and data lines to clk and flags
// SCL edges and START/STOP conditions. Assumes each SCL phase lasts
// several clk periods longer than STAGES.
module synth_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_s;
    logic              scl_d;
    logic              sda_d;

    // Shift raw lines through the synchroniser chain; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    // Keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Decode edges of SCL and SDA transitions while SCL stays high.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/synth_bus_fsm.sv
// Module: byte-level protocol engine. Matches the address, acknowledges
// bytes, presents write bytes to the register bank and shifts status out.
// Assumes edge and condition pulses from synth_line_sync.
module synth_bus_fsm
    import synth_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [1:0] strap_i,
    input  logic [7:0] status,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_byte,
    output logic       xfer_start,
    output logic       rd_done,
    output bus_st_t    state
);
    logic [7:0] shreg;
    logic [2:0] bit_cnt;
    logic       full;
    logic       rw;
    logic       nack;

    // Advance the protocol state on each bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bit_cnt    <= '0;
            full       <= 1'b0;
            rw         <= 1'b0;
            nack       <= 1'b1;
            sda_oe     <= 1'b0;
            wr_stb     <= 1'b0;
            wr_byte    <= '0;
            xfer_start <= 1'b0;
            rd_done    <= 1'b0;
        end else begin
            wr_stb     <= 1'b0;
            xfer_start <= 1'b0;
            rd_done    <= 1'b0;
            if (start_det) begin
                state      <= ST_ADDR;
                bit_cnt    <= '0;
                full       <= 1'b0;
                sda_oe     <= 1'b0;
                xfer_start <= 1'b1;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) full <= 1'b1;
                        end else if (scl_fall && full) begin
                            full <= 1'b0;
                            if (state == ST_WR) begin
                                state  <= ST_WR_ACK;
                                sda_oe <= 1'b1;
                            end else if (shreg[7:3] == DEV_PREFIX &&
                                         shreg[2:1] == strap_i) begin
                                state  <= ST_ADDR_ACK;
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                state  <= ST_RD;
                                shreg  <= status;
                                sda_oe <= ~status[7];
                            end else begin
                                state  <= ST_WR;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            state   <= ST_WR;
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            wr_stb  <= 1'b1;
                            wr_byte <= shreg;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) full <= 1'b1;
                        end else if (scl_fall) begin
                            if (full) begin
                                full    <= 1'b0;
                                sda_oe  <= 1'b0;
                                state   <= ST_RD_ACK;
                                rd_done <= 1'b1;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_RD;
                                shreg   <= status;
                                sda_oe  <= ~status[7];
                                bit_cnt <= '0;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/synth_reg_bank.sv
// Module: classifies written bytes into divider, control and port data,
// holds the outputs and forms the status byte. Assumes one strobe per
// acknowledged data byte and one pulse per START.
module synth_reg_bank
    import synth_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             wr_stb,
    input  logic [7:0]       wr_byte,
    input  logic             rd_done,
    input  logic             lock_i,
    input  logic [2:0]       port_in,
    input  logic [2:0]       lvl_in,
    output logic [DIV_W-1:0] div_ratio,
    output ctrl_t            ctrl,
    output logic [4:0]       port_q,
    output logic [7:0]       status,
    output logic             por_flag
);
    localparam int HI_W = DIV_W - 8;

    expect_t         exp_q;
    logic [HI_W-1:0] div_hi;

    // Sort each data byte and update the matching register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q     <= EXP_ANY;
            div_hi    <= '0;
            div_ratio <= '0;
            ctrl      <= '0;
            port_q    <= '0;
        end else if (xfer_start) begin
            exp_q <= EXP_ANY;
        end else if (wr_stb) begin
            case (exp_q)
                EXP_DIV_LO: begin
                    div_ratio <= {div_hi, wr_byte};
                    exp_q     <= EXP_ANY;
                end
                EXP_PORT: begin
                    port_q <= wr_byte[7:3];
                    exp_q  <= EXP_ANY;
                end
                default: begin
                    if (wr_byte[7]) begin
                        ctrl  <= wr_byte[6:0];
                        exp_q <= EXP_PORT;
                    end else begin
                        div_hi <= wr_byte[HI_W-1:0];
                        exp_q  <= EXP_DIV_LO;
                    end
                end
            endcase
        end
    end

    // Power-on flag: set by reset, cleared once a status byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n)       por_flag <= 1'b1;
        else if (rd_done) por_flag <= 1'b0;
    end

    // Status byte joins the sticky flag with live inputs.
    always_comb status = {por_flag, lock_i, port_in, lvl_in};

endmodule

// File: rtl/synth_ctl_slave.sv
// Module: top of the synthesizer control slave. Wires the line
// synchroniser, protocol engine and register bank. Assumes an external
// open-drain data line: sda_oe high pulls it low.
module synth_ctl_slave
    import synth_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       strap_i,
    input  logic             lock_i,
    input  logic [2:0]       port_in,
    input  logic [2:0]       lvl_in,
    output logic [DIV_W-1:0] div_ratio,
    output logic             cp_sel,
    output logic             test_en,
    output logic             pump_off,
    output logic [2:0]       mode_sel,
    output logic             vdrv_off,
    output logic [4:0]       port_q
);
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       wr_stb;
    logic [7:0] wr_byte;
    logic       xfer_start;
    logic       rd_done;
    logic [7:0] status;
    logic       por_flag;
    bus_st_t    bus_state;
    ctrl_t      ctrl;

    synth_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    synth_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .strap_i    (strap_i),
        .status     (status),
        .sda_oe     (sda_oe),
        .wr_stb     (wr_stb),
        .wr_byte    (wr_byte),
        .xfer_start (xfer_start),
        .rd_done    (rd_done),
        .state      (bus_state)
    );

    synth_reg_bank #(.DIV_W(DIV_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .wr_stb     (wr_stb),
        .wr_byte    (wr_byte),
        .rd_done    (rd_done),
        .lock_i     (lock_i),
        .port_in    (port_in),
        .lvl_in     (lvl_in),
        .div_ratio  (div_ratio),
        .ctrl       (ctrl),
        .port_q     (port_q),
        .status     (status),
        .por_flag   (por_flag)
    );

    // Split the control record onto its output pins.
    always_comb begin
        cp_sel   = ctrl.cp;
        test_en  = ctrl.test;
        pump_off = ctrl.pump_off;
        mode_sel = ctrl.mode;
        vdrv_off = ctrl.vdrv_off;
    end

endmodule

// File: rtl/synth_ctl_chk.sv
// Checker: protocol and register-update properties of synth_ctl_slave,
// attached by bind. Observes ports and a few internal hand-off signals.
module synth_ctl_chk
    import synth_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic [DIV_W-1:0] div_ratio,
    input logic [2:0]       mode_sel,
    input logic [4:0]       port_q,
    input logic             wr_stb,
    input logic             por_flag,
    input bus_st_t          bus_state
);
    // R2: the data line is only ever switched while SCL is low.
    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R4: the divider only moves right after a data-byte strobe.
    a_r4_div_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_ratio) |-> $past(wr_stb));

    // R5: the mode field only moves right after a data-byte strobe.
    a_r5_mode_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_sel) |-> $past(wr_stb));

    // R6: port latches only move right after a data-byte strobe.
    a_r6_port_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_q) |-> $past(wr_stb));

    // R8: once cleared, the power-on flag stays cleared.
    a_r8_por_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !por_flag |=> !por_flag);

    // R9: an idle slave never drives the data line.
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_IDLE) |-> !sda_oe);

endmodule

bind synth_ctl_slave synth_ctl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .div_ratio (div_ratio),
    .mode_sel  (mode_sel),
    .port_q    (port_q),
    .wr_stb    (wr_stb),
    .por_flag  (por_flag),
    .bus_state (bus_state)
);

// File: tb/sim_synth_ctl_slave.sv
// Bench: drives the bus as a master, sweeps straps, divider values, every
// control byte and every status input combination, and checks the ports.
module sim_synth_ctl_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        msda = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [1:0]  strap = 2'b00;
    logic        lock = 1'b0;
    logic [2:0]  pin = 3'b000;
    logic [2:0]  lvl = 3'b000;
    logic [14:0] div_ratio;
    logic        cp_sel, test_en, pump_off, vdrv_off;
    logic [2:0]  mode_sel;
    logic [4:0]  port_q;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = msda & ~sda_oe;

    synth_ctl_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .lock_i(lock), .port_in(pin),
        .lvl_in(lvl), .div_ratio(div_ratio), .cp_sel(cp_sel),
        .test_en(test_en), .pump_off(pump_off), .mode_sel(mode_sel),
        .vdrv_off(vdrv_off), .port_q(port_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; wait_clk(4);
        scl = 1'b1;  wait_clk(4);
        msda = 1'b0; wait_clk(4);
        scl = 1'b0;  wait_clk(4);
    endtask

    task automatic bus_stop();
        msda = 1'b0; wait_clk(4);
        scl = 1'b1;  wait_clk(4);
        msda = 1'b1; wait_clk(8);
    endtask

    task automatic bus_bit(input logic b, output logic got);
        msda = b;    wait_clk(4);
        scl = 1'b1;  wait_clk(4);
        got = sda_line; wait_clk(4);
        scl = 1'b0;  wait_clk(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic g;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], g);
        bus_bit(1'b1, g);
        ack = ~g;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic g;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, g);
            d = {d[6:0], g};
        end
        bus_bit(nack, g);
    endtask

    function automatic logic [7:0] adr(input logic [1:0] ma, input logic rd);
        return {5'b11000, ma, rd};
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Write a full divider pair in one transaction and check it.
    task automatic write_div(input logic [14:0] v);
        logic a;
        bus_start();
        send_byte(adr(strap, 1'b0), a); chk("R1 write addr ack", a, 1);
        send_byte({1'b0, v[14:8]}, a);  chk("R2 div hi ack", a, 1);
        send_byte(v[7:0], a);           chk("R2 div lo ack", a, 1);
        bus_stop();
        chk("R3 divider value", div_ratio, v);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic       a;
        logic       g;
        logic [7:0] d;
        logic [14:0] cur;
        logic [6:0]  c;
        logic [7:0]  p;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R10: reset state
        chk("R10 div after reset", div_ratio, 0);
        chk("R10 ctrl after reset", {cp_sel, test_en, pump_off, mode_sel, vdrv_off}, 0);
        chk("R10 port after reset", port_q, 0);
        chk("R10 sda released", sda_oe, 0);

        // R7 R8 R9: first read with master ack, then nack
        strap = 2'b10; lock = 1'b1; pin = 3'b101; lvl = 3'b011;
        bus_start();
        send_byte(adr(2'b10, 1'b1), a); chk("R1 read addr ack", a, 1);
        recv_byte(1'b0, d); chk("R8 first status has por", d, 8'b1110_1011);
        recv_byte(1'b1, d); chk("R8 second status por clear", d, 8'b0110_1011);
        for (int i = 0; i < 3; i++) begin
            bus_bit(1'b1, g);
            chk("R9 released after nack", g, 1);
        end
        chk("R9 sda_oe low after nack", sda_oe, 0);
        bus_stop();
        bus_start();
        send_byte(adr(2'b10, 1'b1), a);
        recv_byte(1'b1, d); chk("R8 por stays clear", d, 8'b0110_1011);
        bus_stop();

        // R1: strap and address sweep
        for (int s = 0; s < 4; s++) begin
            strap = s[1:0];
            for (int m = 0; m < 4; m++) begin
                bus_start();
                send_byte(adr(m[1:0], 1'b0), a);
                chk("R1 address match", a, (m == s) ? 1 : 0);
                bus_stop();
            end
            bus_start();
            send_byte({5'b10000, s[1:0], 1'b0}, a);
            chk("R1 prefix mismatch", a, 0);
            bus_stop();
        end

        // R1: ignored traffic after mismatch leaves outputs alone
        strap = 2'b01;
        bus_start();
        send_byte(adr(2'b11, 1'b0), a);
        send_byte(8'h9F, a); chk("R1 no ack after mismatch", a, 0);
        send_byte(8'hF8, a);
        bus_stop();
        chk("R1 ctrl unchanged", {cp_sel, test_en, pump_off, mode_sel, vdrv_off}, 0);
        chk("R1 port unchanged", port_q, 0);

        // R3: divider sweep
        write_div(15'h0000);
        write_div(15'h7FFF);
        write_div(15'h4000);
        write_div(15'h0001);
        write_div(15'h2AAA);
        write_div(15'h5555);
        for (int i = 1; i < 9; i++) write_div(15'((i * 32'h1357) & 32'h7FFF));

        // R4: atomic update across the two bytes
        cur = div_ratio;
        bus_start();
        send_byte(adr(strap, 1'b0), a);
        send_byte({1'b0, 7'h12}, a);
        chk("R4 div held between bytes", div_ratio, cur);
        send_byte(8'h34, a);
        bus_stop();
        chk("R4 div after pair", div_ratio, 15'h1234);

        // R4: lone first byte then STOP is dropped
        bus_start();
        send_byte(adr(strap, 1'b0), a);
        send_byte({1'b0, 7'h55}, a);
        bus_stop();
        chk("R4 lone byte dropped", div_ratio, 15'h1234);

        // R11: lone first byte then repeated START, control and port follow
        bus_start();
        send_byte(adr(strap, 1'b0), a);
        send_byte({1'b0, 7'h2B}, a);
        bus_start();
        send_byte(adr(strap, 1'b0), a);
        send_byte(8'b1010_1101, a);
        chk("R11 control after restart", {cp_sel, test_en, pump_off, mode_sel, vdrv_off}, 7'b010_1101);
        chk("R11 div untouched", div_ratio, 15'h1234);
        send_byte(8'b0110_0111, a);
        bus_stop();
        chk("R11 port after restart", port_q, 5'b01100);

        // R3 R5 R6: four data bytes in one write
        bus_start();
        send_byte(adr(strap, 1'b0), a);
        send_byte({1'b0, 7'h3C}, a);
        send_byte(8'hA5, a);
        send_byte(8'b1100_0011, a);
        send_byte(8'b1011_1000, a);
        bus_stop();
        chk("R3 div in full write", div_ratio, {7'h3C, 8'hA5});
        chk("R5 ctrl in full write", {cp_sel, test_en, pump_off, mode_sel, vdrv_off}, 7'b100_0011);
        chk("R6 port in full write", port_q, 5'b10111);

        // R5 R6: every control value, port byte with varying low bits
        for (int v = 0; v < 128; v++) begin
            c = v[6:0];
            p = {c[4:0] ^ 5'b10101, c[2:0] ^ 3'b111};
            bus_start();
            send_byte(adr(strap, 1'b0), a);
            send_byte({1'b1, c}, a);
            send_byte(p, a);
            bus_stop();
            chk("R5 control fields", {cp_sel, test_en, pump_off, mode_sel, vdrv_off}, c);
            chk("R6 port bits, low bits ignored", port_q, p[7:3]);
        end
        chk("R3 div kept by control writes", div_ratio, {7'h3C, 8'hA5});

        // R7: status sweep over bands and port inputs
        for (int l = 0; l < 5; l++) begin
            for (int q = 0; q < 8; q++) begin
                lvl = l[2:0]; pin = q[2:0]; lock = q[0] ^ l[0];
                bus_start();
                send_byte(adr(strap, 1'b1), a);
                recv_byte(1'b1, d);
                bus_stop();
                chk("R7 status byte", d, {1'b0, lock, pin, lvl});
            end
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule